// File: doc/BRIEF.md
# Self-Synchronizing Stream Descrambler

This block recovers the plain bit stream from a serial, scrambled 125 Mbit/s line after NRZI-to-NRZ conversion. It takes one bit per clock with a valid strobe, plus a link-up input. The transmitter scrambles with an 11-bit LFSR whose keystream obeys k[n] = k[n-11] ^ k[n-9] (x^11 + x^9 + 1). Each line bit is plain ^ k. An idle line carries plain ones, so during idle each received bit is the inverted keystream bit.

While hunting, the block fills its keystream register from inverted received bits. Once it holds 11 of them, it predicts each further keystream bit and compares the prediction with the line. A run of 40 consistent idle bits brings it into lock. While locked, the register runs by itself and every valid bit is XORed with its output. A hold timer is loaded on lock and reloaded after every run of 30 consecutive descrambled ones. If the timer runs out, or link-up falls, the block drops lock, signals the loss, clears its state and hunts again.

Top module: `dsc_descrambler`

## Requirements
- R1: Out of reset, locked_o rises on the clock edge that samples the 40th consecutive valid idle bit. The first 11 bits seed the keystream register. The other 29 must each equal the inverse of the predicted keystream bit.
- R2: While hunting, a valid bit that differs from the inverted prediction (after seeding) discards the run. Lock then needs 40 further idle bits after the offending bit.
- R3: While locked, each valid input bit yields bit_o = bit_i ^ k on the next clock edge, with bit_valid_o high for one cycle. Here k is the keystream bit that continues the transmitter's sequence k[n] = k[n-11] ^ k[n-9].
- R4: The hold timer is loaded with HOLD_CYCLES on lock and on the 30th of every run of consecutive descrambled ones. Without a reload, locked_o falls on the HOLD_CYCLES-th clock edge after the last load.
- R5: lock_lost_o is high for exactly one cycle after each exit from lock, whether by timeout or by link loss.
- R6: A low link_up_i clears lock on the next edge, together with the run counter and timer. While link_up_i is low, valid bits are ignored and cannot bring the block into lock.
- R7: After reset, locked_o, lock_lost_o, bit_valid_o and bit_o are all 0.
- R8: Cycles with bit_valid_i low do not advance the keystream. They produce no output and do not change any later descrambled bit.
- R9: While not locked, bit_valid_o stays low and bit_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Scrambled line bit |
| bit_valid_i | input | 1 | bit_i carries a line bit this cycle |
| link_up_i | input | 1 | Link is up; low forces loss of lock |
| bit_o | output | 1 | Descrambled bit |
| bit_valid_o | output | 1 | bit_o is valid |
| locked_o | output | 1 | Descrambler is synchronized |
| lock_lost_o | output | 1 | One-cycle pulse on loss of lock |

## Verification
Each descrambled bit is due one edge after its input is sampled. A scoreboard therefore pushes the expected plain bit when the driver places the line bit at a falling edge, and pops it at the following falling edge. Lock is due on the very edge that samples the 40th idle bit, so it is checked one time unit after that edge and also after the 39th. Loss of lock is counted edge by edge from the last timer load: the bench checks locked_o after edge HOLD_CYCLES-1 and again after edge HOLD_CYCLES, and lock_lost_o on that edge and on the one after. A link drop is checked one edge after link_up_i falls.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int LFSR_W       = 11;
  localparam int LFSR_TAP     = 9;
  localparam int ACQ_RUN      = 40;
  localparam int IDLE_RUN     = 30;
  localparam int HOLD_DEFAULT = 90250;

  typedef enum logic [0:0] {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } dsc_state_e;
endpackage

// File: rtl/dsc_keystream.sv
module dsc_keystream #(
  parameter int W   = 11,
  parameter int TAP = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic shift_i,
  input  logic in_bit_i,
  output logic key_o
);
  logic [W-1:0] sr_q;

  // sr_q[0] newest keystream bit, sr_q[W-1] oldest
  assign key_o = sr_q[W-1] ^ sr_q[TAP-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (clear_i) sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], in_bit_i};
  end

  assert_shift_in_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clear_i) |=> (sr_q[0] == $past(in_bit_i)));
endmodule

// File: rtl/dsc_acquire.sv
module dsc_acquire #(
  parameter int SEED_LEN = 11,
  parameter int RUN_LEN  = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  logic match_i,
  output logic done_o
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] run_q;
  logic seeding, good;

  assign seeding = run_q < CW'(SEED_LEN);
  assign good    = seeding | match_i;
  assign done_o  = step_i & good & (run_q == CW'(RUN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (clear_i) run_q <= '0;
    else if (step_i) begin
      if (!good || done_o) run_q <= '0;
      else                 run_q <= run_q + 1'b1;
    end
  end

  assert_run_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < CW'(RUN_LEN));
  assert_mismatch_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !seeding && !match_i && !clear_i) |=> (run_q == '0));
endmodule

// File: rtl/dsc_hold_timer.sv
module dsc_hold_timer #(
  parameter int HOLD_CYCLES = 90250,
  parameter int IDLE_RUN    = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  input  logic active_i,
  input  logic step_i,
  input  logic bit_i,
  output logic expire_o
);
  localparam int TW = $clog2(HOLD_CYCLES + 1);
  localparam int IW = $clog2(IDLE_RUN + 1);

  logic [TW-1:0] timer_q;
  logic [IW-1:0] ones_q;
  logic reload;

  assign reload   = active_i & step_i & bit_i & (ones_q == IW'(IDLE_RUN - 1));
  assign expire_o = active_i & ~start_i & ~reload & (timer_q == TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ones_q <= '0;
    else if (clear_i || start_i)  ones_q <= '0;
    else if (active_i && step_i) begin
      if (!bit_i || reload) ones_q <= '0;
      else                  ones_q <= ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          timer_q <= '0;
    else if (clear_i)                     timer_q <= '0;
    else if (start_i || reload)           timer_q <= TW'(HOLD_CYCLES);
    else if (active_i && timer_q != '0)   timer_q <= timer_q - 1'b1;
  end

  assert_timer_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_q <= TW'(HOLD_CYCLES));
  assert_reload_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload && !clear_i) |=> (timer_q == TW'(HOLD_CYCLES)));
  assert_live_timer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !start_i) |-> (timer_q != '0));
endmodule

// File: rtl/dsc_descrambler.sv
module dsc_descrambler
  import dsc_pkg::*;
#(
  parameter int HOLD_CYCLES = HOLD_DEFAULT,
  parameter int ACQ_LEN     = ACQ_RUN,
  parameter int IDLE_LEN    = IDLE_RUN,
  parameter int KEY_W       = LFSR_W,
  parameter int KEY_TAP     = LFSR_TAP
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_valid_i,
  input  logic link_up_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic locked_o,
  output logic lock_lost_o
);
  dsc_state_e state_q;
  logic step, hunting, key, match, lock_evt, expire, clear_all, plain;

  assign step      = bit_valid_i & link_up_i;
  assign hunting   = (state_q == ST_HUNT);
  assign match     = (key == ~bit_i);
  assign plain     = bit_i ^ key;
  assign clear_all = ~link_up_i | expire;

  dsc_keystream #(.W(KEY_W), .TAP(KEY_TAP)) i_keystream (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_all),
    .shift_i  (step),
    .in_bit_i (hunting ? ~bit_i : key),
    .key_o    (key)
  );

  dsc_acquire #(.SEED_LEN(KEY_W), .RUN_LEN(ACQ_LEN)) i_acquire (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_all),
    .step_i  (step & hunting),
    .match_i (match),
    .done_o  (lock_evt)
  );

  dsc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES), .IDLE_RUN(IDLE_LEN)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (~link_up_i),
    .start_i  (lock_evt),
    .active_i (~hunting),
    .step_i   (step),
    .bit_i    (plain),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HUNT;
    else if (!link_up_i) state_q <= ST_HUNT;
    else begin
      unique case (state_q)
        ST_HUNT: if (lock_evt) state_q <= ST_LOCK;
        ST_LOCK: if (expire)   state_q <= ST_HUNT;
        default:               state_q <= ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
      lock_lost_o <= 1'b0;
    end else begin
      bit_valid_o <= step & ~hunting;
      bit_o       <= (step & ~hunting) ? plain : 1'b0;
      lock_lost_o <= ~hunting & clear_all;
    end
  end

  assign locked_o = (state_q == ST_LOCK);

  assert_lock_on_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(step));
  assert_link_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_i |=> !locked_o);
  assert_lost_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_lost_o |=> !lock_lost_o);
  assert_lost_unlocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_lost_o |-> !locked_o);
  assert_quiet_hunt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |=> (!bit_valid_o && !bit_o));
endmodule

// File: tb/test_dsc_descrambler.sv
module test_dsc_descrambler;
  localparam int HOLD = 200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0, bit_valid_i = 1'b0, link_up_i = 1'b1;
  logic bit_o, bit_valid_o, locked_o, lock_lost_o;

  int n_checks = 0;
  int n_fail = 0;
  logic exp_q[$];
  logic [10:0] sc = 11'h5A3;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dsc_descrambler #(.HOLD_CYCLES(HOLD)) i_dsc_descrambler (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_valid_i(bit_valid_i),
    .link_up_i(link_up_i), .bit_o(bit_o), .bit_valid_o(bit_valid_o),
    .locked_o(locked_o), .lock_lost_o(lock_lost_o)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // transmitter model: k[n] = k[n-11] ^ k[n-9]
  task automatic send(logic plain, bit expect_out);
    logic k;
    @(negedge clk);
    k = sc[10] ^ sc[8];
    sc = {sc[9:0], k};
    bit_i = plain ^ k;
    bit_valid_i = 1'b1;
    if (expect_out) exp_q.push_back(plain);
  endtask

  task automatic idle_bits(int n, bit expect_out);
    for (int i = 0; i < n; i++) send(1'b1, expect_out);
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid_i = 1'b0;
      bit_i = ~bit_i;
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic e;
    if (rst_ni && bit_valid_o) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R9: actual unexpected output %0d expected none", bit_o);
      end else begin
        e = exp_q.pop_front();
        check("R3 descrambled bit", int'(bit_o), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 locked", locked_o, 0);
    check("R7 lost", lock_lost_o, 0);
    check("R7 valid", bit_valid_o, 0);
    check("R7 bit", bit_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: 39 idle bits do not lock, 40th does
    idle_bits(39, 1'b0);
    settle();
    check("R1 no lock at 39", locked_o, 0);
    check("R9 bit while hunting", bit_o, 0);
    send(1'b1, 1'b0);
    settle();
    check("R1 lock at 40", locked_o, 1);
    check("R5 no pulse on lock", lock_lost_o, 0);

    // R3 / R8: data with a stall in the middle
    for (int i = 0; i < 30; i++) send(logic'(((2 * i + 5) % 11) > 4), 1'b1);
    gap(5);
    settle();
    check("R8 no output in stall", bit_valid_o, 0);
    for (int i = 30; i < 60; i++) send(logic'(((2 * i + 5) % 11) > 4), 1'b1);
    idle_bits(30, 1'b1);
    settle();

    // R4: timer reloaded by the 30-ones run, expires HOLD edges later
    gap(1);
    for (int i = 0; i < HOLD - 1; i++) begin
      @(posedge clk);
      #1;
      if (i == HOLD - 2) check("R4 still locked", locked_o, 1);
    end
    settle();
    check("R4 timeout unlock", locked_o, 0);
    check("R5 pulse on timeout", lock_lost_o, 1);
    settle();
    check("R5 pulse one cycle", lock_lost_o, 0);
    check("R3 scoreboard drained", exp_q.size(), 0);

    // R2: mismatch after seeding discards the run
    idle_bits(25, 1'b0);
    send(1'b0, 1'b0);
    idle_bits(39, 1'b0);
    settle();
    check("R2 no lock 39 after mismatch", locked_o, 0);
    send(1'b1, 1'b0);
    settle();
    check("R2 lock 40 after mismatch", locked_o, 1);

    // R6: link loss
    send(1'b0, 1'b1);
    send(1'b1, 1'b1);
    send(1'b0, 1'b1);
    @(negedge clk);
    bit_valid_i = 1'b0;
    link_up_i = 1'b0;
    settle();
    check("R6 unlock on link down", locked_o, 0);
    check("R5 pulse on link down", lock_lost_o, 1);
    idle_bits(45, 1'b0);
    settle();
    check("R6 no lock while link down", locked_o, 0);
    check("R9 no valid while hunting", bit_valid_o, 0);
    @(negedge clk);
    bit_valid_i = 1'b0;
    link_up_i = 1'b1;
    idle_bits(40, 1'b0);
    settle();
    check("R6 relock after link up", locked_o, 1);

    gap(1);
    repeat (3) settle();
    check("R3 scoreboard empty", exp_q.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule